// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block is a small memory-mapped bank holding one 32-bit word per hart. Bit 0 of each word drives the software interrupt line of that hart, so one hart can interrupt another by storing to the word of its target. The bank decodes word offsets from zero upward, one word per hart. Any offset past the last hart, any offset that is not word aligned, and any access with fewer than four byte lanes enabled reads as zero, and a write to such an offset does nothing.

The parameter `SET_ONLY` picks one of two flavours. With `SET_ONLY = 0` (the machine-level flavour), each word holds a level. Writing 1 raises the line, writing 0 lowers it, and a read returns the current state. With `SET_ONLY = 1` (the supervisor-level flavour), a store of 1 gives a single-cycle pulse on the line. The receiving hart keeps and clears its own pending bit. In this flavour a store of 0 does nothing and every read returns zero.

The bus takes a write in the cycle it is presented. A read is answered one cycle later, with `rsp_valid` high for that one cycle.

Top module: `swi_bank`

## Requirements
- R1: Hart n's word is at byte offset 4*n. For this check an offset is word aligned when `req_addr[1:0]` is 0, and only aligned offsets below 4*NUM_HARTS reach a hart.
- R2: A write to hart n whose bit 0 is 1 raises `irq_o[n]`. In the level flavour, the line is high from the cycle after the write and stays high.
- R3: In the level flavour, a write to hart n whose bit 0 is 0 lowers `irq_o[n]` from the next cycle. Bits 31..1 of the write data have no effect.
- R4: In the set-only flavour, a write of 0 leaves every `irq_o` bit low.
- R5: In the set-only flavour, each write of 1 to hart n makes `irq_o[n]` high for exactly the next cycle. Two such writes in consecutive cycles keep the line high for two cycles.
- R6: In the level flavour, a read of hart n returns the state of the line in bit 0, with bits 31..1 at zero. The state returned is the one before any write presented in the cycle after the read.
- R7: In the set-only flavour, every read returns zero.
- R8: An access counts as a word access only when `req_be` is 4'hF. Any other access, any misaligned offset and any offset at or above 4*NUM_HARTS reads as zero, and a write to it changes no line.
- R9: After reset, all lines are low and `rsp_valid` is low.
- R10: `rsp_valid` is high in exactly the cycle after a read request, including a read that reaches no hart. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_be | input | 4 | Byte-lane enables. Only 4'hF is a word access |
| req_wdata | input | 32 | Write data. Only bit 0 is used |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |
| irq_o | output | NUM_HARTS | Software interrupt line, one per hart |

## Verification
Two things can fall in the same cycle. One is a read response, captured at the edge of the read request, being returned while the next request writes to the same hart. The other is a set-only pulse ending while a second write of 1 starts a new pulse. Both are provoked directly: a read of a hart followed at once by a write that flips it, and two writes of 1 back to back to the same hart. Random traffic then repeats such overlaps at random. Both flavours receive identical traffic in parallel. Each cycle a bench model, built from the requirements, predicts both the returned word, which must carry the value from before the write, and the state of every line.

// File: rtl/swi_pkg.sv
package swi_pkg;

  localparam int unsigned BUS_W = 32;
  localparam logic [3:0]  BE_WORD = 4'hF;

  // An access reaches a register only with all lanes on and a word-aligned offset.
  function automatic logic word_access_ok(input logic [3:0] be, input logic [1:0] low);
    return (be == BE_WORD) && (low == 2'b00);
  endfunction

  // The single meaningful bit of a written word.
  function automatic logic control_bit(input logic [BUS_W-1:0] word);
    return word[0];
  endfunction

  // Response word built from the one readable bit.
  function automatic logic [BUS_W-1:0] pack_resp(input logic b);
    return {{(BUS_W-1){1'b0}}, b};
  endfunction

endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  output logic [NUM_HARTS-1:0] hart_sel,
  output logic                 hit
);
  import swi_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic acc_ok;
  assign acc_ok = word_access_ok(be, addr[1:0]);

  for (genvar n = 0; n < NUM_HARTS; n++) begin : g_sel
    assign hart_sel[n] = acc_ok && (addr[ADDR_W-1:2] == WORD_W'(n));
  end

  assign hit = |hart_sel;
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
  parameter bit SET_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic line_o
);
  logic state_q;

  if (SET_ONLY) begin : g_pulse
    // A store of 1 gives a single-cycle pulse; a store of 0 is dropped.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= 1'b0;
      else        state_q <= wr_en && wr_bit;
    end
  end else begin : g_level
    // The level follows the last stored bit.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state_q <= 1'b0;
      else if (wr_en) state_q <= wr_bit;
    end
  end

  assign line_o = state_q;
endmodule

// File: rtl/swi_rdsel.sv
module swi_rdsel #(
  parameter int unsigned NUM_HARTS = 4,
  parameter bit          SET_ONLY  = 1'b0
) (
  input  logic [NUM_HARTS-1:0] hart_sel,
  input  logic [NUM_HARTS-1:0] lines,
  output logic                 rd_bit
);
  if (SET_ONLY) begin : g_zero
    logic unused_rd;
    assign unused_rd = ^{hart_sel, lines};
    assign rd_bit = 1'b0 & unused_rd;
  end else begin : g_mux
    assign rd_bit = |(hart_sel & lines);
  end
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_HARTS = 4,
  parameter bit          SET_ONLY  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_be,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] irq_o
);
  import swi_pkg::*;

  // Named internal events, observed by the bound checker.
  logic [NUM_HARTS-1:0] hart_sel;
  logic                 hit;
  logic                 wr_fire;
  logic                 rd_fire;
  logic                 wr_bit;
  logic                 rd_bit;
  logic                 rsp_bit_q;
  logic                 rsp_valid_q;

  swi_decode #(.ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS)) u_decode (
    .addr     (req_addr),
    .be       (req_be),
    .hart_sel (hart_sel),
    .hit      (hit)
  );

  assign wr_fire = req_valid && req_write && hit;
  assign rd_fire = req_valid && !req_write;
  assign wr_bit  = control_bit(req_wdata);

  for (genvar n = 0; n < NUM_HARTS; n++) begin : g_hart
    swi_cell #(.SET_ONLY(SET_ONLY)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_fire && hart_sel[n]),
      .wr_bit (wr_bit),
      .line_o (irq_o[n])
    );
  end

  swi_rdsel #(.NUM_HARTS(NUM_HARTS), .SET_ONLY(SET_ONLY)) u_rdsel (
    .hart_sel (hart_sel),
    .lines    (irq_o),
    .rd_bit   (rd_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_bit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rd_fire;
      rsp_bit_q   <= rd_fire && rd_bit;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = pack_resp(rsp_bit_q);
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_HARTS = 4,
  parameter bit          SET_ONLY  = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [31:0]          req_wdata,
  input logic                 rsp_valid,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_HARTS-1:0] irq_o,
  input logic [NUM_HARTS-1:0] hart_sel,
  input logic                 wr_fire
);

  // R1
  hart_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hart_sel));

  // R1
  past_end_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(req_addr) >= 4 * NUM_HARTS) |-> (hart_sel == '0));

  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R10
  no_rsp_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R6
  rsp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[31:1] == '0);

  if (SET_ONLY) begin : g_set_only
    // R5
    pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && req_wdata[0]) |=> ((irq_o & $past(hart_sel)) == $past(hart_sel)));

    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> (irq_o == '0));

    // R4
    zero_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !req_wdata[0]) |=> (irq_o == '0));

    // R7
    read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rdata == '0);

    // R8
    bad_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !wr_fire) |=> (irq_o == '0));
  end else begin : g_level
    // R2
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && req_wdata[0]) |=> ((irq_o & $past(hart_sel)) == $past(hart_sel)));

    // R3
    level_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !req_wdata[0]) |=> ((irq_o & $past(hart_sel)) == '0));

    // R8
    bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !wr_fire) |=> $stable(irq_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(irq_o));
  end

endmodule

bind swi_bank swi_bank_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_HARTS (NUM_HARTS),
  .SET_ONLY  (SET_ONLY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .irq_o     (irq_o),
  .hart_sel  (hart_sel),
  .wr_fire   (wr_fire)
);

// File: tb/swi_bank_tb.sv
module swi_bank_tb;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NH     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_be = 4'h0;
  logic [31:0]       req_wdata = '0;

  logic              rv_m, rv_s;
  logic [31:0]       rd_m, rd_s;
  logic [NH-1:0]     irq_m, irq_s;

  always #10 clk = ~clk;   // 50 MHz

  swi_bank #(.ADDR_W(ADDR_W), .NUM_HARTS(NH), .SET_ONLY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rv_m), .rsp_rdata(rd_m), .irq_o(irq_m)
  );

  swi_bank #(.ADDR_W(ADDR_W), .NUM_HARTS(NH), .SET_ONLY(1'b1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rv_s), .rsp_rdata(rd_s), .irq_o(irq_s)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench model, built from the requirements.
  logic [NH-1:0] m_level = '0;
  logic [NH-1:0] m_pulse = '0;
  logic          m_rv = 1'b0;
  logic          m_rbit = 1'b0;

  // R1, R8: the word of a hart is reached only with all lanes, alignment, and an offset in range.
  function automatic bit reaches(input logic [ADDR_W-1:0] a, input logic [3:0] be);
    return (be == 4'hF) && (a % 4 == 0) && (int'(a) / 4 < NH);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare last cycle's outputs, then advance the model and drive the next access.
  task automatic step(input string tag, input bit v, input bit w,
                      input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    check({tag, " R2/R3 level lines"}, 32'(irq_m), 32'(m_level));
    check({tag, " R5 pulse lines"},    32'(irq_s), 32'(m_pulse));
    check({tag, " R10 rsp_valid"},     {30'b0, rv_s, rv_m}, {30'b0, m_rv, m_rv});
    check({tag, " R6 level read"},     rd_m, {31'b0, m_rbit});
    check({tag, " R7 set-only read"},  rd_s, 32'h0);
    begin
      bit hit;
      int idx;
      hit = v && reaches(a, be);
      idx = int'(a) / 4;
      m_rv    = v && !w;
      m_rbit  = (v && !w && hit) ? m_level[idx] : 1'b0;
      m_pulse = '0;
      if (v && w && hit) begin
        m_level[idx] = d[0];
        if (d[0]) m_pulse[idx] = 1'b1;
      end
    end
    req_valid = v; req_write = w; req_addr = a; req_be = be; req_wdata = d;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: state held in reset
    check("R9 level lines in reset", 32'(irq_m), 32'h0);
    check("R9 pulse lines in reset", 32'(irq_s), 32'h0);
    check("R9 rsp_valid in reset",   {30'b0, rv_s, rv_m}, 32'h0);
    rst_n = 1'b1;

    step("R9 idle",          0, 0, 12'h000, 4'hF, 32'h0);
    step("R2 set h0",        1, 1, 12'h000, 4'hF, 32'h1);
    step("R6 read h0",       1, 0, 12'h000, 4'hF, 32'h0);
    step("R3 clr h0 hi bits",1, 1, 12'h000, 4'hF, 32'hFFFF_FFFE);
    step("R6 read h0 clear", 1, 0, 12'h000, 4'hF, 32'h0);
    step("R1 set last hart", 1, 1, 12'(4*(NH-1)), 4'hF, 32'h1);
    step("R1 past end wr",   1, 1, 12'(4*NH), 4'hF, 32'h1);
    step("R1 past end rd",   1, 0, 12'(4*NH), 4'hF, 32'h0);
    step("R8 misaligned wr", 1, 1, 12'h005, 4'hF, 32'h1);
    step("R8 misaligned rd", 1, 0, 12'h00D, 4'hF, 32'h0);
    step("R8 half lanes wr", 1, 1, 12'h004, 4'h3, 32'h1);
    step("R8 half lanes rd", 1, 0, 12'(4*(NH-1)), 4'h1, 32'h0);
    step("R6 read last",     1, 0, 12'(4*(NH-1)), 4'hF, 32'h0);
    step("R6 flip after rd", 1, 1, 12'(4*(NH-1)), 4'hF, 32'h0);
    step("R5 pulse h2 a",    1, 1, 12'h008, 4'hF, 32'h1);
    step("R5 pulse h2 b",    1, 1, 12'h008, 4'hF, 32'h1);
    step("R4 zero wr h2",    1, 1, 12'h008, 4'hF, 32'h0);
    step("R4 idle",          0, 1, 12'h008, 4'hF, 32'h1);
    step("R7 read h1",       1, 0, 12'h004, 4'hF, 32'h0);

    for (int i = 0; i < 600; i++) begin
      bit v, w;
      logic [ADDR_W-1:0] a;
      logic [3:0] be;
      logic [31:0] d;
      v  = ($urandom_range(0, 9) != 0);
      w  = $urandom_range(0, 1) == 1;
      a  = 12'($urandom_range(0, 4*NH + 7));
      be = ($urandom_range(0, 4) != 0) ? 4'hF : 4'($urandom_range(0, 14));
      d  = $urandom;
      step("R2 random", v, w, a, be, d);
    end
    step("R10 final", 0, 0, 12'h0, 4'h0, 32'h0);
    step("R10 drain", 0, 0, 12'h0, 4'h0, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule